// File: doc/BRIEF.md
# Configuration-Select Issue Stage

This block sits between instruction fetch and the execution units of a reconfigurable DSP engine. Every 24-bit instruction carries a 3-bit selector that names one of eight 128-bit configuration registers. When the stage accepts an instruction, it issues that instruction on the next cycle together with the full configuration word the selector picks. A short instruction therefore controls a wide datapath setup for each cycle.

Program code fills the configuration registers at run time through a narrow load port. Each register takes four 32-bit beats. A register becomes usable only when its final beat arrives. A write that completes in the same cycle as an issue reading that register is forwarded straight to the issue. If an instruction selects a register that has never finished loading, fetch is stalled until the register completes.

Top module: `cfg_issue_stage`

## Requirements
- R1: After reset, `iss_valid` is 0, `iss_instr` and `iss_cfg` are all zero, and every configuration register is invalid, so `fetch_ready` is 0 for every selector while no load is completing.
- R2: Instruction fields are opcode in bits [23:16], selector in bits [15:13] and operands in bits [12:0]. The issued `iss_instr` equals the accepted instruction bit for bit.
- R3: An instruction is accepted in a cycle when `fetch_valid` and `fetch_ready` are both 1. In the next cycle `iss_valid` is 1 and `iss_cfg` holds the selected register's contents. In a cycle with no acceptance, `iss_valid` is 0 on the next cycle and `iss_instr`/`iss_cfg` keep their values.
- R4: A load is four consecutive beats with `ld_valid` high. Beat i fills bits [32i+31:32i] of the register. The target register is the `ld_sel` presented with the first beat, and `ld_sel` on later beats is ignored.
- R5: A register that has not been loaded before stays invalid through the first three beats of its load. While it is invalid, `fetch_ready` is 0 for instructions that select it.
- R6: In the cycle of a load's fourth beat, an instruction selecting the target register sees `fetch_ready` = 1. If that instruction is accepted, it issues with the newly loaded word.
- R7: While a register that already holds a valid word is being reloaded, instructions accepted before the fourth beat issue with the old word.
- R8: While fetch is stalled on an invalid register, no issue occurs. Once the stall clears, the held instruction is accepted.
- R9: A load changes only its target register. The other registers keep their contents and their validity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch presents an instruction |
| fetch_instr | input | 24 | Instruction word from fetch |
| fetch_ready | output | 1 | Stage can accept the presented instruction |
| ld_valid | input | 1 | Configuration load beat present |
| ld_sel | input | 3 | Target register, sampled on the first beat |
| ld_data | input | 32 | Load beat data |
| iss_valid | output | 1 | Issue output holds a new instruction |
| iss_instr | output | 24 | Issued instruction |
| iss_cfg | output | 128 | Configuration word issued with the instruction |

## Verification
The hardest situation to reach is the single cycle in which a load's last beat and an accepted instruction name the same register. This case exercises forwarding, the release of a stall, and the switch from an old word to a new one all at once. The stimulus drives load beats and fetch from the same task loop, so the bench can place an instruction that selects the target register on each beat of the load. This placement is used in three ways: against a register that has never been loaded (stall, then forward), against a valid register being reloaded (old word three times, then the new word), and from the very first load after reset.

// File: rtl/cfg_issue_pkg.sv
package cfg_issue_pkg;

    // Instruction word layout; the selector position is decoded by the issue logic.
    typedef struct packed {
        logic [7:0]  opcode;
        logic [2:0]  cn;
        logic [12:0] operands;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);
    localparam int CN_W    = 3;

endpackage

// File: rtl/cfg_beat_loader.sv
module cfg_beat_loader #(
    parameter int CFG_W  = 128,
    parameter int BEAT_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [BEAT_W-1:0] ld_data,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [CFG_W-1:0]  wr_data
);
    localparam int BEATS = CFG_W / BEAT_W;
    localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1;
    localparam int ACC_W = CFG_W - BEAT_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic [ACC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic last_beat;

    always_comb begin
        st_d      = st_q;
        last_beat = ld_valid && (st_q.cnt == LAST);
        if (ld_valid) begin
            if (st_q.cnt == '0) begin
                st_d.sel = ld_sel;
            end
            if (last_beat) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.acc[st_q.cnt*BEAT_W +: BEAT_W] = ld_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = last_beat;
    assign wr_sel  = st_q.sel;
    assign wr_data = {ld_data, st_q.acc};

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int NUM_CFG = 8,
    parameter int CFG_W   = 128,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [CFG_W-1:0] rd_data,
    output logic             rd_valid
);
    typedef struct packed {
        logic             vld;
        logic [CFG_W-1:0] data;
    } ent_t;

    ent_t ent_d [NUM_CFG];
    ent_t ent_q [NUM_CFG];

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en && (wr_sel == SEL_W'(g))) begin
                ent_d[g].vld  = 1'b1;
                ent_d[g].data = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
            end
        end
    end

    logic fwd;

    always_comb begin
        fwd      = wr_en && (wr_sel == rd_sel);
        rd_data  = fwd ? wr_data : ent_q[rd_sel].data;
        rd_valid = fwd || ent_q[rd_sel].vld;
    end

endmodule

// File: rtl/cfg_issue_ctrl.sv
module cfg_issue_ctrl
    import cfg_issue_pkg::*;
#(
    parameter int CFG_W = 128,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  instr_t           fetch_instr,
    output logic             fetch_ready,
    output logic [SEL_W-1:0] rd_sel,
    input  logic [CFG_W-1:0] rd_data,
    input  logic             rd_valid,
    output logic             iss_valid,
    output instr_t           iss_instr,
    output logic [CFG_W-1:0] iss_cfg
);
    typedef struct packed {
        logic             vld;
        instr_t           instr;
        logic [CFG_W-1:0] cfg;
    } iss_t;

    iss_t iss_d, iss_q;
    logic accept;

    always_comb begin
        rd_sel      = SEL_W'(fetch_instr.cn);
        fetch_ready = rd_valid;
        accept      = fetch_valid && rd_valid;
        iss_d       = iss_q;
        iss_d.vld   = accept;
        if (accept) begin
            iss_d.instr = fetch_instr;
            iss_d.cfg   = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_q <= '0;
        end else begin
            iss_q <= iss_d;
        end
    end

    assign iss_valid = iss_q.vld;
    assign iss_instr = iss_q.instr;
    assign iss_cfg   = iss_q.cfg;

endmodule

// File: rtl/cfg_issue_stage.sv
module cfg_issue_stage
    import cfg_issue_pkg::*;
#(
    parameter int NUM_CFG = 8,
    parameter int CFG_W   = 128,
    parameter int BEAT_W  = 32,
    parameter int SEL_W   = CN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [INSTR_W-1:0] fetch_instr,
    output logic               fetch_ready,
    input  logic               ld_valid,
    input  logic [SEL_W-1:0]   ld_sel,
    input  logic [BEAT_W-1:0]  ld_data,
    output logic               iss_valid,
    output logic [INSTR_W-1:0] iss_instr,
    output logic [CFG_W-1:0]   iss_cfg
);
    logic             cmt_en;
    logic [SEL_W-1:0] cmt_sel;
    logic [CFG_W-1:0] cmt_data;
    logic [SEL_W-1:0] rd_sel;
    logic [CFG_W-1:0] rd_data;
    logic             rd_valid;
    instr_t           iss_word;

    cfg_beat_loader #(.CFG_W(CFG_W), .BEAT_W(BEAT_W), .SEL_W(SEL_W)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_valid(ld_valid),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .wr_en   (cmt_en),
        .wr_sel  (cmt_sel),
        .wr_data (cmt_data)
    );

    cfg_reg_bank #(.NUM_CFG(NUM_CFG), .CFG_W(CFG_W), .SEL_W(SEL_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmt_en),
        .wr_sel  (cmt_sel),
        .wr_data (cmt_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    cfg_issue_ctrl #(.CFG_W(CFG_W), .SEL_W(SEL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_valid(fetch_valid),
        .fetch_instr(instr_t'(fetch_instr)),
        .fetch_ready(fetch_ready),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .iss_valid  (iss_valid),
        .iss_instr  (iss_word),
        .iss_cfg    (iss_cfg)
    );

    assign iss_instr = iss_word;

endmodule

// File: rtl/cfg_issue_checker.sv
module cfg_issue_checker
    import cfg_issue_pkg::*;
#(
    parameter int CFG_W = 128,
    parameter int SEL_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_valid,
    input logic               fetch_ready,
    input logic [INSTR_W-1:0] fetch_instr,
    input logic               iss_valid,
    input logic [INSTR_W-1:0] iss_instr,
    input logic [CFG_W-1:0]   iss_cfg,
    input logic               wr_en,
    input logic [SEL_W-1:0]   wr_sel,
    input logic [CFG_W-1:0]   wr_data
);
    instr_t fi;
    logic   hs;
    logic   hit;

    assign fi  = instr_t'(fetch_instr);
    assign hs  = fetch_valid && fetch_ready;
    assign hit = wr_en && (wr_sel == SEL_W'(fi.cn));

    AST_ISSUE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> iss_valid && (iss_instr == $past(fetch_instr))); // R3
    AST_NO_ACCEPT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !hs |=> !iss_valid); // R8
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hs |=> $stable(iss_instr) && $stable(iss_cfg)); // R3
    AST_READY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> fetch_ready); // R6
    AST_FORWARD_NEW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && hit) |=> (iss_cfg == $past(wr_data))); // R6

endmodule

bind cfg_issue_stage cfg_issue_checker #(.CFG_W(CFG_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready),
    .fetch_instr(fetch_instr),
    .iss_valid  (iss_valid),
    .iss_instr  (iss_instr),
    .iss_cfg    (iss_cfg),
    .wr_en      (cmt_en),
    .wr_sel     (cmt_sel),
    .wr_data    (cmt_data)
);

// File: tb/cfg_issue_stage_test.sv
module cfg_issue_stage_test;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         fetch_valid;
    logic [23:0]  fetch_instr;
    logic         fetch_ready;
    logic         ld_valid;
    logic [2:0]   ld_sel;
    logic [31:0]  ld_data;
    logic         iss_valid;
    logic [23:0]  iss_instr;
    logic [127:0] iss_cfg;

    int tests = 0;
    int fails = 0;
    logic [127:0] model [8];

    cfg_issue_stage uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_instr(fetch_instr), .fetch_ready(fetch_ready),
        .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_data(ld_data),
        .iss_valid(iss_valid), .iss_instr(iss_instr), .iss_cfg(iss_cfg)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct packed {
        logic [23:0] instr;
        logic [2:0]  exp_sel;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{ {8'h10, 3'd5, 13'h1ABC}, 3'd5 },
        '{ {8'h21, 3'd0, 13'h0001}, 3'd0 },
        '{ {8'hFF, 3'd7, 13'h1FFF}, 3'd7 },
        '{ {8'h00, 3'd3, 13'h0000}, 3'd3 },
        '{ {8'h5A, 3'd3, 13'h0AAA}, 3'd3 },
        '{ {8'h7E, 3'd1, 13'h1555}, 3'd1 },
        '{ {8'h42, 3'd6, 13'h0123}, 3'd6 },
        '{ {8'h99, 3'd2, 13'h1000}, 3'd2 }
    };

    function automatic logic [31:0] beat_of(int k, int gen, int b);
        return {8'(gen), 8'(k), 8'(b), 8'h5A};
    endfunction

    function automatic logic [127:0] word_of(int k, int gen);
        return {beat_of(k, gen, 3), beat_of(k, gen, 2), beat_of(k, gen, 1), beat_of(k, gen, 0)};
    endfunction

    function automatic logic [23:0] mk(logic [7:0] op, logic [2:0] sel, logic [12:0] opr);
        return {op, sel, opr};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fetch_valid = 1'b0; fetch_instr = '0;
        ld_valid = 1'b0; ld_sel = '0; ld_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Full four-beat load with fetch idle.
    task automatic load_cfg(int k, int gen);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            fetch_valid = 1'b0;
            ld_valid = 1'b1; ld_sel = 3'(k); ld_data = beat_of(k, gen, b);
        end
        @(negedge clk);
        ld_valid = 1'b0;
        model[k] = word_of(k, gen);
    endtask

    initial begin
        #(CLK_P * 50000);
        tests++; fails++;
        $display("FAIL watchdog R3: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        #1;
        chk("R1 iss_valid", 128'(iss_valid), 128'd0);
        chk("R1 iss_cfg", iss_cfg, 128'd0);
        fetch_instr = mk(8'h01, 3'd4, 13'h0); #1;
        chk("R1 ready invalid reg", 128'(fetch_ready), 128'd0);

        // First load of reg 0 with a fetch selecting it held on every beat.
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            ld_valid = 1'b1; ld_sel = 3'd0; ld_data = beat_of(0, 0, b);
            fetch_valid = 1'b1; fetch_instr = mk(8'hC3, 3'd0, 13'h0042);
            #1;
            chk(b < 3 ? "R5 ready before last beat" : "R6 ready on last beat",
                128'(fetch_ready), (b < 3) ? 128'd0 : 128'd1);
            @(posedge clk); #1;
            chk("R8 no issue while stalled / issue on release", 128'(iss_valid), (b < 3) ? 128'd0 : 128'd1);
        end
        chk("R6 forwarded word", iss_cfg, word_of(0, 0));
        chk("R4 beat order", iss_cfg[63:32], beat_of(0, 0, 1));
        model[0] = word_of(0, 0);
        @(negedge clk); ld_valid = 1'b0; fetch_valid = 1'b0;

        for (int k = 1; k < 8; k++) load_cfg(k, 0);

        // Table walk, back-to-back issue.
        foreach (VEC[i]) begin
            @(negedge clk);
            fetch_valid = 1'b1; fetch_instr = VEC[i].instr;
            @(posedge clk); #1;
            chk("R3 iss_valid", 128'(iss_valid), 128'd1);
            chk("R2 iss_instr", 128'(iss_instr), 128'(VEC[i].instr));
            chk("R3 iss_cfg", iss_cfg, model[VEC[i].exp_sel]);
        end

        // R3: idle cycle holds outputs.
        @(negedge clk); fetch_valid = 1'b0; fetch_instr = mk(8'h00, 3'd1, 13'h0);
        @(posedge clk); #1;
        chk("R3 no issue when idle", 128'(iss_valid), 128'd0);
        chk("R3 instr held", 128'(iss_instr), 128'(VEC[7].instr));
        chk("R3 cfg held", iss_cfg, model[2]);

        // R7: reload reg 3 while issuing from it.
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            ld_valid = 1'b1; ld_sel = 3'd3; ld_data = beat_of(3, 1, b);
            fetch_valid = 1'b1; fetch_instr = mk(8'h33, 3'd3, 13'(b));
            @(posedge clk); #1;
            chk(b < 3 ? "R7 old word during reload" : "R6 new word on last beat",
                iss_cfg, (b < 3) ? word_of(3, 0) : word_of(3, 1));
        end
        model[3] = word_of(3, 1);
        @(negedge clk);
        ld_valid = 1'b0; fetch_valid = 1'b1; fetch_instr = mk(8'h55, 3'd5, 13'h0);
        @(posedge clk); #1;
        chk("R9 other register unchanged", iss_cfg, word_of(5, 0));
        @(negedge clk);
        fetch_instr = mk(8'h56, 3'd3, 13'h0);
        @(posedge clk); #1;
        chk("R7 reloaded word persists", iss_cfg, word_of(3, 1));

        // R4: selector taken from first beat only.
        do_reset();
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            ld_valid = 1'b1; ld_sel = (b == 0) ? 3'd6 : 3'd1; ld_data = beat_of(6, 2, b);
        end
        @(negedge clk);
        ld_valid = 1'b0; fetch_valid = 1'b0; fetch_instr = mk(8'h01, 3'd1, 13'h0); #1;
        chk("R4 later ld_sel ignored", 128'(fetch_ready), 128'd0);
        fetch_valid = 1'b1; fetch_instr = mk(8'h66, 3'd6, 13'h0);
        @(posedge clk); #1;
        chk("R4 first-beat target loaded", iss_cfg, word_of(6, 2));
        @(negedge clk); fetch_valid = 1'b0;
        fetch_instr = mk(8'h02, 3'd2, 13'h0); #1;
        chk("R9 untouched register still invalid", 128'(fetch_ready), 128'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule